// File: doc/BRIEF.md
# Multiple-Register Block Transfer Sequencer

This block moves a group of registers between an eight-entry register file and memory, one 32-bit word per memory beat. A start pulse brings in the direction (load or store), the index of the register that holds the base address, and an eight-bit mask that selects which registers take part. The sequencer works out each address, orders the beats, tags each beat as sequential or non-sequential, and writes the updated base back into the register file.

The base address is word-aligned for the transfer. Its two low bits are kept aside and added back into the written-back value. The block has special rules for three cases: a base register that is also in the mask, a load's trailing idle cycle, and an empty mask. An empty mask becomes a single program-counter transfer, and the base advances by 0x40.

Memory sees one request at a time on a valid/ready pair. Register reads go through a combinational read port, and register writes go through a write strobe with address and data. A separate strobe writes the program counter and asks the pipeline to flush.

Top module: `blk_xfer_seq`

## Requirements
- R1: A start pulse taken while idle raises busy from the next cycle until the done cycle. A start pulse while busy is ignored and does not change the transfer in progress.
- R2: Beat addresses begin at the base value with bits [1:0] cleared. Selected registers go out in ascending index order (bit i of the mask selects register i), and the address grows by 4 after each beat.
- R3: The first beat of a transfer has mem_seq_o = 0 and every later beat has mem_seq_o = 1. mem_write_o = 1 marks a store.
- R4: While mem_valid_o is high and mem_ready_i is low, the address, direction and tag stay the same in the next cycle.
- R5: A load writes each selected register with the word read at its beat. If the base register is not in the mask, it then receives aligned base + 4·n + saved low bits. If the base register is in the mask, it keeps the loaded word.
- R6: A load has one idle cycle after its last beat. done_o is sampled high two clock edges after the last beat's accepting edge for a load, and one edge after it for a store.
- R7: A store always writes the base register back with aligned base + 4·n + saved low bits.
- R8: On a store where the base register is in the mask, its stored word is its original value if it is the lowest selected index. Otherwise the stored word is the written-back value of R7.
- R9: An empty-mask load makes one beat at the aligned base. It writes the read word with bit 0 cleared to the program counter with a one-cycle flush strobe, and sets the base to its original value + 0x40.
- R10: An empty-mask store makes one beat at the aligned base that stores pc_i + 2, and sets the base to its original value + 0x40.
- R11: done_o is high for exactly one cycle per transfer, and busy_o is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (taken only while idle) |
| load_i | input | 1 | 1 = load from memory, 0 = store to memory |
| base_idx_i | input | 3 | Index of the base register |
| list_i | input | 8 | Register selection mask |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 32 | Word address of the beat |
| mem_write_o | output | 1 | Beat is a write |
| mem_seq_o | output | 1 | Beat is sequential |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with mem_ready_i |
| rf_raddr_o | output | 3 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write strobe |
| rf_waddr_o | output | 3 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| pc_i | input | 32 | Current program counter |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_wdata_o | output | 32 | New program counter value |
| flush_o | output | 1 | Pipeline flush strobe |

## Verification
The first beat is requested in the cycle after the accepting edge of start. Each loaded register is written on the edge that accepts its beat, and the program counter is written the same way. The base writeback and done_o come one edge after the last beat for a store, and two edges after it for a load. The bench monitors the memory and register ports on every clock edge and records the edge number of the last accepted beat and of done. It compares the gap between them against these counts. It drives inputs and reads the final state only on falling edges.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  parameter int EMPTY_STEP = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    load_i,
  input  logic [$clog2(NREG)-1:0] base_idx_i,
  input  logic [NREG-1:0]         list_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    mem_valid_o,
  input  logic                    mem_ready_i,
  output logic [XLEN-1:0]         mem_addr_o,
  output logic                    mem_write_o,
  output logic                    mem_seq_o,
  output logic [XLEN-1:0]         mem_wdata_o,
  input  logic [XLEN-1:0]         mem_rdata_i,
  output logic [$clog2(NREG)-1:0] rf_raddr_o,
  input  logic [XLEN-1:0]         rf_rdata_i,
  output logic                    rf_we_o,
  output logic [$clog2(NREG)-1:0] rf_waddr_o,
  output logic [XLEN-1:0]         rf_wdata_o,
  input  logic [XLEN-1:0]         pc_i,
  output logic                    pc_we_o,
  output logic [XLEN-1:0]         pc_wdata_o,
  output logic                    flush_o
);
  localparam int IW = $clog2(NREG);

  typedef enum logic [1:0] {S_IDLE, S_BEAT, S_GAP, S_WB} st_t;

  st_t            st;
  logic           load_r, empty_r, first_r, inlist_r;
  logic [IW-1:0]  base_r;
  logic [NREG-1:0] rem_r;
  logic [XLEN-1:0] addr_r, wb_r;

  function automatic logic [IW-1:0] lowest(input logic [NREG-1:0] v);
    lowest = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (v[i]) lowest = IW'(i);
  endfunction

  logic [IW-1:0]   cur;
  logic [NREG-1:0] rem_next;
  logic            fire, accept, last;
  logic [XLEN-1:0] aligned;

  assign cur      = lowest(rem_r);
  assign rem_next = rem_r & ~(NREG'(1) << cur);
  assign fire     = mem_valid_o && mem_ready_i;
  assign accept   = start_i && st == S_IDLE;
  assign last     = empty_r || rem_next == '0;
  assign aligned  = {rf_rdata_i[XLEN-1:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      load_r <= 1'b0; empty_r <= 1'b0; first_r <= 1'b0; inlist_r <= 1'b0;
      base_r <= '0; rem_r <= '0; addr_r <= '0; wb_r <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st       <= S_BEAT;
          load_r   <= load_i;
          empty_r  <= list_i == '0;
          first_r  <= 1'b1;
          inlist_r <= list_i[base_idx_i];
          base_r   <= base_idx_i;
          rem_r    <= list_i;
          addr_r   <= aligned;
          wb_r     <= (list_i == '0) ? rf_rdata_i + XLEN'(EMPTY_STEP)
                    : aligned + (XLEN'($countones(list_i)) << 2) + XLEN'(rf_rdata_i[1:0]);
        end
        S_BEAT: if (fire) begin
          addr_r  <= addr_r + XLEN'(4);
          first_r <= 1'b0;
          rem_r   <= rem_next;
          if (last) st <= load_r ? S_GAP : S_WB;
        end
        S_GAP:   st <= S_WB;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = st != S_IDLE;
  assign done_o      = st == S_WB;
  assign mem_valid_o = st == S_BEAT;
  assign mem_addr_o  = addr_r;
  assign mem_write_o = !load_r;
  assign mem_seq_o   = !first_r;
  assign mem_wdata_o = empty_r ? pc_i + XLEN'(2)
                     : (cur == base_r && !first_r) ? wb_r : rf_rdata_i;

  assign rf_raddr_o  = (st == S_IDLE) ? base_idx_i : cur;
  assign rf_we_o     = (fire && load_r && !empty_r)
                     || (st == S_WB && (!load_r || empty_r || !inlist_r));
  assign rf_waddr_o  = (st == S_BEAT) ? cur : base_r;
  assign rf_wdata_o  = (st == S_BEAT) ? mem_rdata_i : wb_r;

  assign pc_we_o     = fire && load_r && empty_r;
  assign pc_wdata_o  = {mem_rdata_i[XLEN-1:1], 1'b0};
  assign flush_o     = pc_we_o;

  assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!mem_valid_o || mem_addr_o == $past(mem_addr_o) + XLEN'(4)));

  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> mem_addr_o[1:0] == 2'b00);

  assert_seq_after_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!mem_valid_o || mem_seq_o));

  assert_hold_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_seq_o) && $stable(mem_write_o)));

  assert_pc_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (pc_we_o && !pc_wdata_o[0] && !mem_write_o));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
endmodule

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start_i = 0, load_i = 0, mem_ready_i = 0;
  logic [2:0] base_idx_i = 0;
  logic [7:0] list_i = 0;
  logic busy_o, done_o, mem_valid_o, mem_write_o, mem_seq_o;
  logic rf_we_o, pc_we_o, flush_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o, pc_wdata_o;
  logic [2:0] rf_raddr_o, rf_waddr_o;

  logic [31:0] mem [1024];
  logic [31:0] rf_m [8];
  logic [31:0] pc_m;

  assign mem_rdata_i = mem[mem_addr_o[11:2]];
  assign rf_rdata_i  = rf_m[rf_raddr_o];

  blk_xfer_seq u_blk_xfer_seq (
    .clk, .rst_n, .start_i, .load_i, .base_idx_i, .list_i, .busy_o, .done_o,
    .mem_valid_o, .mem_ready_i, .mem_addr_o, .mem_write_o, .mem_seq_o,
    .mem_wdata_o, .mem_rdata_i, .rf_raddr_o, .rf_rdata_i, .rf_we_o,
    .rf_waddr_o, .rf_wdata_o, .pc_i(pc_m), .pc_we_o, .pc_wdata_o, .flush_o);

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int cyc = 0, beat_n = 0, last_fire_cyc = 0, done_cyc = 0, done_cnt = 0, flush_cnt = 0;
  logic [31:0] b_addr [16];
  logic [31:0] b_wdata [16];
  logic        b_seq [16];
  logic        b_wr [16];
  logic        stall_p = 0;
  logic [31:0] stall_addr;
  logic        stall_seq;

  always @(posedge clk) begin
    if (rst_n) begin
      if (stall_p) begin
        chk(mem_valid_o && mem_addr_o == stall_addr && mem_seq_o == stall_seq,
            "R4 hold", mem_addr_o, stall_addr);
      end
      stall_p = mem_valid_o && !mem_ready_i;
      stall_addr = mem_addr_o;
      stall_seq = mem_seq_o;
      if (mem_valid_o && mem_ready_i) begin
        if (beat_n < 16) begin
          b_addr[beat_n] = mem_addr_o; b_wdata[beat_n] = mem_wdata_o;
          b_seq[beat_n] = mem_seq_o;   b_wr[beat_n] = mem_write_o;
        end
        beat_n++;
        last_fire_cyc = cyc;
        if (mem_write_o) mem[mem_addr_o[11:2]] = mem_wdata_o;
      end
      if (rf_we_o) rf_m[rf_waddr_o] = rf_wdata_o;
      if (pc_we_o) pc_m = pc_wdata_o;
      if (flush_o) flush_cnt++;
      if (done_o) begin done_cyc = cyc; done_cnt++; end
    end
    cyc++;
  end

  always @(negedge clk) mem_ready_i <= ($urandom % 3) != 0;

  task automatic run(input bit ld, input logic [2:0] b, input logic [7:0] lst, input bit poke);
    logic [31:0] exp_rf [8];
    logic [31:0] exp_addr [8];
    logic [31:0] exp_wd [8];
    logic [31:0] base, al, wbv, exp_pc;
    int n, k, fl0, dc0, to;
    int first;
    @(negedge clk);
    base = 32'h100 + ($urandom % 32'hC00);
    rf_m[b] = base;
    for (int i = 0; i < 8; i++) exp_rf[i] = rf_m[i];
    al = base & ~32'h3;
    n = $countones(lst);
    wbv = al + 32'(n * 4) + (base & 32'h3);
    exp_pc = pc_m;
    first = -1;
    for (int i = 7; i >= 0; i--) if (lst[i]) first = i;
    k = 0;
    for (int i = 0; i < 8; i++) if (lst[i]) begin
      exp_addr[k] = al + 32'(k * 4);
      if (ld) exp_rf[i] = mem[exp_addr[k][11:2]];
      else exp_wd[k] = (i == int'(b) && i != first) ? wbv : rf_m[i];
      k++;
    end
    if (n == 0) begin
      exp_addr[0] = al;
      if (ld) exp_pc = mem[al[11:2]] & ~32'h1;
      else exp_wd[0] = pc_m + 32'h2;
      exp_rf[b] = base + 32'h40;
    end else if (!ld || !lst[b]) exp_rf[b] = wbv;
    beat_n = 0; fl0 = flush_cnt; dc0 = done_cnt;
    start_i = 1; load_i = ld; base_idx_i = b; list_i = lst;
    @(negedge clk);
    start_i = 0;
    chk(busy_o, "R1 busy after start", 32'(busy_o), 1);
    if (poke) begin
      start_i = 1; load_i = !ld; base_idx_i = b + 3'd1; list_i = ~lst;
      @(negedge clk);
      start_i = 0;
    end
    to = 0;
    while (done_cnt == dc0 && to < 300) begin @(negedge clk); to++; end
    chk(to < 300, "R1 watchdog", to, 0);
    chk(!busy_o && !done_o, "R11 idle after done", {busy_o, done_o}, 0);
    k = (n == 0) ? 1 : n;
    chk(beat_n == k, "R2 beat count", beat_n, k);
    for (int j = 0; j < k && j < beat_n; j++) begin
      chk(b_addr[j] == exp_addr[j], "R2 beat address", b_addr[j], exp_addr[j]);
      chk(b_seq[j] == (j != 0), "R3 seq tag", 32'(b_seq[j]), 32'(j != 0));
      chk(b_wr[j] == !ld, "R3 direction", 32'(b_wr[j]), 32'(!ld));
      if (!ld) chk(b_wdata[j] == exp_wd[j], n == 0 ? "R10 empty store data" : "R8 store data",
                   b_wdata[j], exp_wd[j]);
    end
    for (int i = 0; i < 8; i++)
      chk(rf_m[i] == exp_rf[i], n == 0 ? (ld ? "R9 base" : "R10 base")
                                       : (ld ? "R5 register" : "R7 register"), rf_m[i], exp_rf[i]);
    chk(pc_m == exp_pc, "R9 program counter", pc_m, exp_pc);
    chk(flush_cnt - fl0 == ((ld && n == 0) ? 1 : 0), "R9 flush strobe", flush_cnt - fl0,
        (ld && n == 0) ? 1 : 0);
    chk(done_cnt - dc0 == 1, "R11 one done", done_cnt - dc0, 1);
    chk(done_cyc - last_fire_cyc == (ld ? 2 : 1), "R6 done timing", done_cyc - last_fire_cyc,
        ld ? 2 : 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    for (int i = 0; i < 8; i++) rf_m[i] = $urandom;
    pc_m = 32'h0800_1234;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_valid_o && !rf_we_o && !pc_we_o, "R1 reset state",
        {busy_o, done_o, mem_valid_o}, 0);
    rst_n = 1;
    @(negedge clk);
    run(1, 3'd2, 8'b1010_0101, 0);
    run(1, 3'd0, 8'b0000_0001, 0);
    run(1, 3'd5, 8'b1111_1111, 1);
    run(0, 3'd1, 8'b0000_0110, 0);
    run(0, 3'd4, 8'b0011_0010, 1);
    run(0, 3'd7, 8'b1000_0000, 0);
    run(1, 3'd3, 8'h00, 0);
    run(0, 3'd6, 8'h00, 1);
    run(0, 3'd2, 8'hFF, 0);
    for (int t = 0; t < 60; t++)
      run(1'($urandom), 3'($urandom), ($urandom % 8 == 0) ? 8'h00 : 8'($urandom), 1'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule